// File: doc/BRIEF.md
# Flash Command, Status and Interrupt Register Unit

This block holds the command, configuration, controller-status and interrupt registers of a memory-mapped flash controller. Software writes 16-bit values into these registers. A write to the command register starts an operation. When the opcode is one the unit recognises, the unit passes it to an external executor as a one-cycle strobe. The executor performs the array, buffer and lock work, then returns a single-cycle completion carrying a kind code and an error flag. The unit turns that completion into interrupt flags and sticky error bits.

The interrupt output is the global pending flag XOR-ed with an inverted polarity bit from configuration register 1. The unit registers this output, so it changes one clock after its inputs change. While the pending flag is set, the unit refuses new commands. Software acknowledges by writing a mask to the interrupt register, which ANDs the mask into the register. If the pending flag is clear after that AND, the sticky error bits in the status register are cleared as well. A completion of kind reset performs a warm reinitialisation of the registers. The synchronous `rst` input performs the cold reset.

Top module: `fciu_top`

## Requirements
- R1: After `rst`, the registers read as follows: configuration 1 = 0x40C0, configuration 2 = 0, status = 0, interrupt = 0x8080, command = 0. In the same state, `ready` = 1, `irq` = 1 and `cmd_strobe` = 0. Register addresses are: 0 command, 1 configuration 1, 2 configuration 2, 3 status, 4 interrupt.
- R2: A write to the command register while interrupt bit 15 is 1 is ignored. The command register keeps its value and no strobe follows.
- R3: An accepted write of a recognised opcode raises `cmd_strobe` for exactly one cycle, in the cycle after the write, with `cmd_opcode` equal to the written value. The recognised opcodes are 0x00, 0x13, 0x80, 0x1A, 0x1B, 0x23, 0x27, 0x2A, 0x2C, 0x30, 0x65, 0x71, 0x94, 0x95, 0xB0, 0xF0 and 0xF3.
- R4: An accepted write of any other opcode produces no strobe. In the cycle after the write, status bit 10 and interrupt bit 15 become set.
- R5: A completion with `done_kind` 1 (load) sets interrupt bits 15 and 7. Kind 2 (program) sets bits 15 and 6. Kind 3 (erase) sets bits 15 and 5. Kind 0 or kinds 5 to 7 (generic) set bit 15 only. When `done_err` is 1, the completion also sets status bit 10, plus bit 13 for load, bit 12 for program or bit 11 for erase.
- R6: A write to the interrupt register ANDs the written value into it. If bit 15 is 0 after the AND, status bits 13..10 are cleared; otherwise they are kept.
- R7: `irq` equals interrupt bit 15 XOR the inverse of configuration 1 bit 6, as registered one clock after the change.
- R8: On each configuration 1 write, `ready` takes bit 7 of the written value. Any reset sets `ready` to 1.
- R9: Reading configuration 1 returns the stored value with bits 4..0 forced to zero. Configuration 2 reads back exactly as written.
- R10: A completion with `done_kind` 4 (reset) causes a warm reset. Afterwards: configuration 1 = 0x40C0, configuration 2 = 0, status = 0, interrupt = 0x8010, command = 0, and `ready` = 1.
- R11: Writes to the status register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high cold reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| cmd_strobe | output | 1 | One-cycle start pulse to the executor |
| cmd_opcode | output | 16 | Opcode for the executor |
| done_valid | input | 1 | Executor completion pulse |
| done_kind | input | 3 | Completion kind: 0 generic, 1 load, 2 program, 3 erase, 4 reset |
| done_err | input | 1 | Completion failed |
| irq | output | 1 | Interrupt output, polarity set by configuration 1 bit 6 |
| ready | output | 1 | Ready output |

## Verification
A stuck or wrongly set pending flag shows up at the ports one cycle after the write that depends on it. A command is then rejected or accepted wrongly, which is visible as a missing or extra `cmd_strobe`. One cycle after that, `irq` settles to the wrong level. Mishandled sticky errors appear in the status readback right after the acknowledging interrupt write. The bench therefore samples every register and output in the exact cycle that each requirement implies. It checks that a stale `irq` value persists for exactly one cycle and no longer.

// File: rtl/fciu_pkg.sv
package fciu_pkg;

    localparam int REG_W = 16;

    // Register addresses
    localparam logic [2:0] RA_CMD  = 3'd0;
    localparam logic [2:0] RA_CFG1 = 3'd1;
    localparam logic [2:0] RA_CFG2 = 3'd2;
    localparam logic [2:0] RA_STAT = 3'd3;
    localparam logic [2:0] RA_INT  = 3'd4;

    // Interrupt register bit positions
    localparam int INT_PEND_BIT  = 15;
    localparam int INT_RST_BIT   = 4;
    localparam int INT_ERASE_BIT = 5;
    localparam int INT_PROG_BIT  = 6;
    localparam int INT_LOAD_BIT  = 7;

    // Status register sticky error bit positions
    localparam int ERR_CMD_BIT   = 10;
    localparam int ERR_ERASE_BIT = 11;
    localparam int ERR_PROG_BIT  = 12;
    localparam int ERR_LOAD_BIT  = 13;
    localparam logic [REG_W-1:0] ERR_MASK = 16'h3C00;

    // Configuration 1 control bits
    localparam int CFG1_POL_BIT = 6;
    localparam int CFG1_RDY_BIT = 7;
    localparam logic [REG_W-1:0] CFG1_RD_MASK = 16'hFFE0;

    // Reset values
    localparam logic [REG_W-1:0] CFG1_RST_VAL = 16'h40C0;
    localparam logic [REG_W-1:0] INT_COLD_VAL = 16'h8080;
    localparam logic [REG_W-1:0] INT_WARM_VAL = 16'h8010;
    localparam logic IRQ_RST_VAL = INT_COLD_VAL[INT_PEND_BIT] ^ ~CFG1_RST_VAL[CFG1_POL_BIT];

    // Opcodes the unit forwards to the executor
    localparam int NUM_OPS = 17;
    localparam logic [7:0] OP_LIST [NUM_OPS] = '{
        8'h00, 8'h13, 8'h80, 8'h1A, 8'h1B, 8'h23, 8'h27, 8'h2A, 8'h2C,
        8'h30, 8'h65, 8'h71, 8'h94, 8'h95, 8'hB0, 8'hF0, 8'hF3
    };

    typedef enum logic [2:0] {
        KIND_GENERIC = 3'd0,
        KIND_LOAD    = 3'd1,
        KIND_PROG    = 3'd2,
        KIND_ERASE   = 3'd3,
        KIND_RESET   = 3'd4
    } done_kind_e;

    typedef struct packed {
        logic [REG_W-1:0] int_set;
        logic [REG_W-1:0] err_set;
    } evt_t;

    // Interrupt and error bits raised by one completion of the given kind
    function automatic evt_t done_event(input logic [2:0] kind, input logic err);
        evt_t e;
        e.int_set = '0;
        e.err_set = '0;
        e.int_set[INT_PEND_BIT] = 1'b1;
        e.err_set[ERR_CMD_BIT]  = err;
        case (kind)
            KIND_LOAD: begin
                e.int_set[INT_LOAD_BIT] = 1'b1;
                e.err_set[ERR_LOAD_BIT] = err;
            end
            KIND_PROG: begin
                e.int_set[INT_PROG_BIT] = 1'b1;
                e.err_set[ERR_PROG_BIT] = err;
            end
            KIND_ERASE: begin
                e.int_set[INT_ERASE_BIT] = 1'b1;
                e.err_set[ERR_ERASE_BIT] = err;
            end
            KIND_RESET: begin
                e.int_set = '0;
                e.err_set = '0;
            end
            default: ;
        endcase
        return e;
    endfunction

endpackage

// File: rtl/fciu_opcode_match.sv
module fciu_opcode_match
    import fciu_pkg::*;
#(
    parameter int OP_W = REG_W
) (
    input  logic [OP_W-1:0] opcode,
    output logic            known
);
    logic [NUM_OPS-1:0] hit;

    for (genvar i = 0; i < NUM_OPS; i++) begin : g_cmp
        assign hit[i] = (opcode == OP_W'(OP_LIST[i]));
    end

    assign known = |hit;
endmodule

// File: rtl/fciu_cmd_port.sv
module fciu_cmd_port
    import fciu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             warm_rst,
    input  logic             cmd_we,
    input  logic [REG_W-1:0] cmd_wdata,
    input  logic             int_pend,
    output logic [REG_W-1:0] cmd_q,
    output logic             cmd_strobe,
    output logic             unknown_pulse
);
    logic pend_q;
    logic known;
    logic accept;

    assign accept = cmd_we && !int_pend;

    always_ff @(posedge clk) begin
        if (rst || warm_rst) begin
            cmd_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            pend_q <= accept;
            if (accept) begin
                cmd_q <= cmd_wdata;
            end
        end
    end

    fciu_opcode_match #(.OP_W(REG_W)) u_match (
        .opcode (cmd_q),
        .known  (known)
    );

    assign cmd_strobe    = pend_q && known;
    assign unknown_pulse = pend_q && !known;

    // R2: a write while pending never leads to a strobe
    a_r2_reject_when_pending: assert property (@(posedge clk) disable iff (rst)
        (cmd_we && int_pend) |=> !cmd_strobe);

    // R3: a strobe is always preceded by an accepted write
    a_r3_strobe_after_write: assert property (@(posedge clk) disable iff (rst)
        cmd_strobe |-> $past(cmd_we && !int_pend));
endmodule

// File: rtl/fciu_event_regs.sv
module fciu_event_regs
    import fciu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             warm_rst,
    input  logic             int_we,
    input  logic [REG_W-1:0] wdata,
    input  logic             unknown_pulse,
    input  logic             done_valid,
    input  logic [2:0]       done_kind,
    input  logic             done_err,
    output logic [REG_W-1:0] int_q,
    output logic [REG_W-1:0] stat_q
);
    evt_t             evt;
    logic [REG_W-1:0] set_int;
    logic [REG_W-1:0] set_err;
    logic [REG_W-1:0] int_and;
    logic [REG_W-1:0] stat_kept;

    always_comb begin
        evt = done_event(done_kind, done_err);
        set_int = '0;
        set_err = '0;
        if (done_valid) begin
            set_int = evt.int_set;
            set_err = evt.err_set;
        end
        if (unknown_pulse) begin
            set_int[INT_PEND_BIT] = 1'b1;
            set_err[ERR_CMD_BIT]  = 1'b1;
        end
        int_and   = int_we ? (int_q & wdata) : int_q;
        stat_kept = (int_we && !int_and[INT_PEND_BIT]) ? (stat_q & ~ERR_MASK) : stat_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            int_q  <= INT_COLD_VAL;
            stat_q <= '0;
        end else if (warm_rst) begin
            int_q  <= INT_WARM_VAL;
            stat_q <= '0;
        end else begin
            int_q  <= int_and | set_int;
            stat_q <= stat_kept | set_err;
        end
    end

    // R4: unknown opcode flags error and pending
    a_r4_unknown_flags: assert property (@(posedge clk) disable iff (rst)
        (unknown_pulse && !warm_rst) |=> (int_q[INT_PEND_BIT] && stat_q[ERR_CMD_BIT]));

    // R5: a load completion raises its type bit and the pending flag
    a_r5_load_done: assert property (@(posedge clk) disable iff (rst)
        (done_valid && done_kind == KIND_LOAD) |=> (int_q[INT_PEND_BIT] && int_q[INT_LOAD_BIT]));

    // R6: acknowledging with bit 15 low and no new event clears the errors
    a_r6_clear_errors: assert property (@(posedge clk) disable iff (rst)
        (int_we && !wdata[INT_PEND_BIT] && !done_valid && !unknown_pulse) |=> ((stat_q & ERR_MASK) == '0));

    // R6: bits written as zero are cleared when no event coincides
    a_r6_and_write: assert property (@(posedge clk) disable iff (rst)
        (int_we && !done_valid && !unknown_pulse) |=> ((int_q & ~$past(wdata)) == '0));

    // R10: warm reset reloads interrupt and status
    a_r10_warm_values: assert property (@(posedge clk) disable iff (rst)
        warm_rst |=> (int_q == INT_WARM_VAL && stat_q == '0));
endmodule

// File: rtl/fciu_cfg_regs.sv
module fciu_cfg_regs
    import fciu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             warm_rst,
    input  logic             cfg1_we,
    input  logic             cfg2_we,
    input  logic [REG_W-1:0] wdata,
    input  logic             int_pend,
    output logic [REG_W-1:0] cfg1_q,
    output logic [REG_W-1:0] cfg2_q,
    output logic             ready,
    output logic             irq
);
    always_ff @(posedge clk) begin
        if (rst || warm_rst) begin
            cfg1_q <= CFG1_RST_VAL;
            cfg2_q <= '0;
            ready  <= 1'b1;
        end else begin
            if (cfg1_we) begin
                cfg1_q <= wdata;
                ready  <= wdata[CFG1_RDY_BIT];
            end
            if (cfg2_we) begin
                cfg2_q <= wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq <= IRQ_RST_VAL;
        end else begin
            irq <= int_pend ^ ~cfg1_q[CFG1_POL_BIT];
        end
    end

    // R8: ready takes bit 7 of a configuration 1 write
    a_r8_ready_follows: assert property (@(posedge clk) disable iff (rst)
        (cfg1_we && !warm_rst) |=> (ready == $past(wdata[CFG1_RDY_BIT])));

    // R8/R10: any warm reset raises ready
    a_r8_ready_on_warm: assert property (@(posedge clk) disable iff (rst)
        warm_rst |=> ready);
endmodule

// File: rtl/fciu_top.sv
module fciu_top
    import fciu_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    output logic              cmd_strobe,
    output logic [REG_W-1:0]  cmd_opcode,
    input  logic              done_valid,
    input  logic [2:0]        done_kind,
    input  logic              done_err,
    output logic              irq,
    output logic              ready
);
    logic             warm_rst;
    logic             cmd_we, cfg1_we, cfg2_we, int_we;
    logic [REG_W-1:0] cmd_q, cfg1_q, cfg2_q, int_q, stat_q;
    logic             unknown_pulse;

    assign warm_rst = done_valid && (done_kind == KIND_RESET);
    assign cmd_we   = wr_en && (wr_addr == ADDR_W'(RA_CMD));
    assign cfg1_we  = wr_en && (wr_addr == ADDR_W'(RA_CFG1));
    assign cfg2_we  = wr_en && (wr_addr == ADDR_W'(RA_CFG2));
    assign int_we   = wr_en && (wr_addr == ADDR_W'(RA_INT));

    fciu_cmd_port u_cmd (
        .clk           (clk),
        .rst           (rst),
        .warm_rst      (warm_rst),
        .cmd_we        (cmd_we),
        .cmd_wdata     (wr_data),
        .int_pend      (int_q[INT_PEND_BIT]),
        .cmd_q         (cmd_q),
        .cmd_strobe    (cmd_strobe),
        .unknown_pulse (unknown_pulse)
    );

    fciu_event_regs u_evt (
        .clk           (clk),
        .rst           (rst),
        .warm_rst      (warm_rst),
        .int_we        (int_we),
        .wdata         (wr_data),
        .unknown_pulse (unknown_pulse),
        .done_valid    (done_valid),
        .done_kind     (done_kind),
        .done_err      (done_err),
        .int_q         (int_q),
        .stat_q        (stat_q)
    );

    fciu_cfg_regs u_cfg (
        .clk      (clk),
        .rst      (rst),
        .warm_rst (warm_rst),
        .cfg1_we  (cfg1_we),
        .cfg2_we  (cfg2_we),
        .wdata    (wr_data),
        .int_pend (int_q[INT_PEND_BIT]),
        .cfg1_q   (cfg1_q),
        .cfg2_q   (cfg2_q),
        .ready    (ready),
        .irq      (irq)
    );

    assign cmd_opcode = cmd_q;

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(RA_CMD))       rd_data = cmd_q;
        else if (rd_addr == ADDR_W'(RA_CFG1)) rd_data = cfg1_q & CFG1_RD_MASK;
        else if (rd_addr == ADDR_W'(RA_CFG2)) rd_data = cfg2_q;
        else if (rd_addr == ADDR_W'(RA_STAT)) rd_data = stat_q;
        else if (rd_addr == ADDR_W'(RA_INT))  rd_data = int_q;
    end

    // R7: irq tracks pending flag and polarity with one cycle of latency
    a_r7_irq_polarity: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq == ($past(int_q[INT_PEND_BIT]) ^ ~$past(cfg1_q[CFG1_POL_BIT]))));

    // R11: status changes only through events or acknowledge writes
    a_r11_status_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (!int_we && !done_valid && !unknown_pulse) |=> $stable(stat_q));
endmodule

// File: tb/tb_fciu_top.sv
module tb_fciu_top;
    import fciu_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [2:0]  wr_addr;
    logic [15:0] wr_data;
    logic [2:0]  rd_addr;
    logic [15:0] rd_data;
    logic        cmd_strobe;
    logic [15:0] cmd_opcode;
    logic        done_valid;
    logic [2:0]  done_kind;
    logic        done_err;
    logic        irq;
    logic        ready;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    fciu_top #(.ADDR_W(3)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .cmd_strobe(cmd_strobe),
        .cmd_opcode(cmd_opcode), .done_valid(done_valid), .done_kind(done_kind),
        .done_err(done_err), .irq(irq), .ready(ready)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%04h expected=0x%04h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        rd_addr = a;
        #0.5;
        d = rd_data;
    endtask

    task automatic done(input logic [2:0] k, input logic e);
        @(negedge clk);
        done_valid = 1'b1; done_kind = k; done_err = e;
        @(negedge clk);
        done_valid = 1'b0; done_err = 1'b0; done_kind = 3'd0;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rst = 1'b1;
        repeat (3) step();
        rst = 1'b0;
        step();
        rd(RA_CFG1, v); chk("R1 cfg1", v, 16'h40C0);
        rd(RA_CFG2, v); chk("R1 cfg2", v, 16'h0000);
        rd(RA_STAT, v); chk("R1 status", v, 16'h0000);
        rd(RA_INT, v);  chk("R1 int", v, 16'h8080);
        rd(RA_CMD, v);  chk("R1 cmd", v, 16'h0000);
        chk("R1 ready", 16'(ready), 16'h1);
        chk("R1 irq", 16'(irq), 16'h1);
        chk("R1 strobe", 16'(cmd_strobe), 16'h0);
    endtask

    task automatic t_reject();
        logic [15:0] v;
        wr(RA_CMD, 16'h0000);
        chk("R2 no strobe", 16'(cmd_strobe), 16'h0);
        step();
        chk("R2 no strobe later", 16'(cmd_strobe), 16'h0);
        wr(RA_CMD, 16'h0094);
        rd(RA_CMD, v); chk("R2 cmd unchanged", v, 16'h0000);
    endtask

    task automatic t_ack_irq();
        logic [15:0] v;
        wr(RA_INT, 16'h0000);
        rd(RA_INT, v); chk("R6 int cleared", v, 16'h0000);
        chk("R7 irq stale one cycle", 16'(irq), 16'h1);
        step();
        chk("R7 irq low after clear", 16'(irq), 16'h0);
    endtask

    task automatic t_accept_erase();
        logic [15:0] v;
        wr(RA_CMD, 16'h0094);
        chk("R3 strobe", 16'(cmd_strobe), 16'h1);
        chk("R3 opcode", cmd_opcode, 16'h0094);
        step();
        chk("R3 strobe one cycle", 16'(cmd_strobe), 16'h0);
        rd(RA_CMD, v); chk("R3 cmd readback", v, 16'h0094);
        done(3'd3, 1'b0);
        rd(RA_INT, v); chk("R5 erase int", v, 16'h8020);
        rd(RA_STAT, v); chk("R5 erase no err", v, 16'h0000);
        step();
        chk("R7 irq high on pending", 16'(irq), 16'h1);
        wr(RA_CMD, 16'h0080);
        rd(RA_CMD, v); chk("R2 reject while pending", v, 16'h0094);
        chk("R2 no strobe pending", 16'(cmd_strobe), 16'h0);
    endtask

    task automatic t_prog_err_ack();
        logic [15:0] v;
        wr(RA_INT, 16'h0000);
        wr(RA_CMD, 16'h0080);
        chk("R3 prog strobe", 16'(cmd_strobe), 16'h1);
        done(3'd2, 1'b1);
        rd(RA_INT, v);  chk("R5 prog int", v, 16'h8040);
        rd(RA_STAT, v); chk("R5 prog err", v, 16'h1400);
        wr(RA_INT, 16'hFFBF);
        rd(RA_INT, v);  chk("R6 and keeps 15", v, 16'h8000);
        rd(RA_STAT, v); chk("R6 errors kept", v, 16'h1400);
        wr(RA_INT, 16'h7FFF);
        rd(RA_INT, v);  chk("R6 and clears 15", v, 16'h0000);
        rd(RA_STAT, v); chk("R6 errors cleared", v, 16'h0000);
    endtask

    task automatic t_load_generic();
        logic [15:0] v;
        wr(RA_CMD, 16'h0013);
        chk("R3 load strobe", 16'(cmd_strobe), 16'h1);
        done(3'd1, 1'b1);
        rd(RA_INT, v);  chk("R5 load int", v, 16'h8080);
        rd(RA_STAT, v); chk("R5 load err", v, 16'h2400);
        wr(RA_INT, 16'h0000);
        wr(RA_CMD, 16'h0023);
        chk("R3 lock strobe", 16'(cmd_strobe), 16'h1);
        done(3'd0, 1'b1);
        rd(RA_INT, v);  chk("R5 generic int", v, 16'h8000);
        rd(RA_STAT, v); chk("R5 generic err", v, 16'h0400);
        wr(RA_STAT, 16'h0000);
        rd(RA_STAT, v); chk("R11 status write ignored", v, 16'h0400);
        wr(RA_STAT, 16'hFFFF);
        rd(RA_STAT, v); chk("R11 status write ones ignored", v, 16'h0400);
        wr(RA_INT, 16'h0000);
        done(3'd6, 1'b0);
        rd(RA_INT, v);  chk("R5 kind 6 generic", v, 16'h8000);
        rd(RA_STAT, v); chk("R5 kind 6 no err", v, 16'h0000);
        wr(RA_INT, 16'h0000);
    endtask

    task automatic t_unknown();
        logic [15:0] v;
        wr(RA_CMD, 16'h0055);
        chk("R4 no strobe", 16'(cmd_strobe), 16'h0);
        step();
        rd(RA_INT, v);  chk("R4 int pending", v, 16'h8000);
        rd(RA_STAT, v); chk("R4 cmd err", v, 16'h0400);
        chk("R4 no strobe later", 16'(cmd_strobe), 16'h0);
        wr(RA_INT, 16'h0000);
        rd(RA_STAT, v); chk("R6 unknown err cleared", v, 16'h0000);
    endtask

    task automatic t_cfg();
        logic [15:0] v;
        step();
        wr(RA_CFG1, 16'h003F);
        rd(RA_CFG1, v); chk("R9 cfg1 masked", v, 16'h0020);
        chk("R8 ready low", 16'(ready), 16'h0);
        chk("R7 irq before update", 16'(irq), 16'h0);
        step();
        chk("R7 irq inverted polarity", 16'(irq), 16'h1);
        wr(RA_CFG1, 16'h00C0);
        chk("R8 ready high", 16'(ready), 16'h1);
        step();
        chk("R7 irq normal polarity", 16'(irq), 16'h0);
        wr(RA_CFG2, 16'hABCD);
        rd(RA_CFG2, v); chk("R9 cfg2 readback", v, 16'hABCD);
    endtask

    task automatic t_warm();
        logic [15:0] v;
        wr(RA_CFG1, 16'h0005);
        chk("R8 ready low pre warm", 16'(ready), 16'h0);
        wr(RA_CMD, 16'h00F3);
        chk("R3 reset strobe", 16'(cmd_strobe), 16'h1);
        done(3'd4, 1'b1);
        rd(RA_INT, v);  chk("R10 int warm", v, 16'h8010);
        rd(RA_CFG1, v); chk("R10 cfg1", v, 16'h40C0);
        rd(RA_CFG2, v); chk("R10 cfg2", v, 16'h0000);
        rd(RA_STAT, v); chk("R10 status", v, 16'h0000);
        rd(RA_CMD, v);  chk("R10 cmd", v, 16'h0000);
        chk("R10 ready", 16'(ready), 16'h1);
    endtask

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
        done_valid = 1'b0; done_kind = '0; done_err = 1'b0;
        t_reset();
        t_reject();
        t_ack_irq();
        t_accept_erase();
        t_prog_err_ack();
        t_load_generic();
        t_unknown();
        t_cfg();
        t_warm();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 50000 && !finished) begin
            checks = checks + 1;
            failures = failures + 1;
            $display("FAIL watchdog expired actual=%0d expected=<50000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule